// File: doc/BRIEF.md
# Sequencer RAM Integrity Scrubber

This block looks after the working copy of command-sequence microcode held in a sequencer RAM. The master image lives in a nonvolatile backing store that the block reads through a simple synchronous port. Coming out of reset, the block copies every word of the image into the RAM. It then makes one verify pass over the copy. If any word disagrees, it sets a sticky error flag.

After that the block waits for configure strobes. Each accepted strobe starts a consistency check, which compares the RAM against the backing store one word at a time and stops at the first word that differs. A check that finds a difference raises a warning, rewrites the whole RAM from the backing store, and only then pulses done. A backing store or RAM cell that keeps getting corrupted shows up as a run of repaired configures. When three repairs come in a row, a sticky store-suspect flag is set. A saturating counter records the total number of repairs.

Top module: `seqram_scrubber`

## Requirements
- R1: Out of reset, the block writes store word a into RAM word a for every address from 0 to DEPTH-1 in rising order. Each word takes two cycles: a store read, then a RAM write. busy is high from reset until the done pulse, and done is high for exactly one cycle at the end of every operation.
- R2: The power-on load ends with one verify pass that stops at the first differing word. A difference sets err, which stays set until reset. A clean pass leaves err low. The whole power-on sequence lasts 2*DEPTH plus 2*(k+1) plus 1 cycles when the first difference is at word k, and 4*DEPTH+1 cycles when there is none.
- R3: A configure request is accepted only at a clock edge where cfg_req is high and busy is low. Acceptance starts a word-by-word check, one store read and one RAM read every two cycles.
- R4: A check that finds no difference makes no RAM write. It keeps busy high for 2*DEPTH+1 cycles and ends with warn low.
- R5: A check whose first difference is at word k rewrites all DEPTH RAM words from the store. It keeps busy high for 2*(k+1)+2*DEPTH+1 cycles and ends with warn high and the RAM equal to the store.
- R6: A cfg_req that is high while busy is high is dropped and is not queued. No new operation starts after the current done pulse.
- R7: repair_count goes up by one for each configure that needed a rewrite. It holds at 2^CNT_W-1 once it gets there.
- R8: Every configure that needs a rewrite adds one to a run of consecutive repairs, and a clean configure clears the run. store_suspect is set when the run reaches SUSPECT_N (3) and stays set until reset.
- R9: warn, err, store_suspect and repair_count take their new values in the same cycle that done is high. warn clears at the edge that accepts the next configure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| cfg_req | input | 1 | Configure request, sampled at every edge |
| busy | output | 1 | High during load, verify, check, rewrite and the done cycle |
| done | output | 1 | One-cycle pulse at the end of each operation |
| warn | output | 1 | Last configure needed a repair |
| err | output | 1 | Power-on verify found a difference (sticky) |
| store_suspect | output | 1 | SUSPECT_N consecutive repairs seen (sticky) |
| repair_count | output | CNT_W | Saturating count of repaired configures |
| store_rd | output | 1 | Backing store read enable |
| store_addr | output | AW | Backing store word address |
| store_data | input | WIDTH | Store read data, valid the cycle after store_rd |
| ram_rd | output | 1 | Sequencer RAM read enable |
| ram_we | output | 1 | Sequencer RAM write enable |
| ram_addr | output | AW | Sequencer RAM word address |
| ram_wdata | output | WIDTH | Sequencer RAM write data |
| ram_rdata | input | WIDTH | RAM read data, valid the cycle after ram_rd |

## Verification
The bench places corruption at word 0, at the last word and in the middle. The length of the busy window shows whether the check really stops at the first difference and whether the rewrite restarts at address 0; a design that scanned on or started the rewrite at the bad word would drop done at the wrong cycle. A stuck RAM bit makes every repair come back, which drives store_suspect and the saturation of repair_count. A design that wrapped the counter, or did not clear the run after a clean configure, would disagree with the reference model. Requests sent during a busy window check that they are dropped rather than queued. A reset with the stuck bit present checks that the power-on verify sets err.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_LD_RD,
    S_LD_WR,
    S_VF_RD,
    S_VF_CMP,
    S_CK_RD,
    S_CK_CMP,
    S_RW_RD,
    S_RW_WR,
    S_FIN
  } scrub_state_e;
endpackage

// File: rtl/scrub_addr_ctr.sv
module scrub_addr_ctr #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          last
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  assign addr_en = clr | inc;

  always_comb begin
    addr_d = addr_q;
    if (clr)      addr_d = '0;
    else if (inc) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;
  assign last = (addr_q == TOP);

  // R1: the word address never leaves the image
  a_r1_addr_in_image: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= TOP);
endmodule

// File: rtl/scrub_fsm.sv
module scrub_fsm
  import scrub_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_req,
  input  logic         last,
  input  logic         differ,
  output scrub_state_e state,
  output logic         addr_clr,
  output logic         addr_inc,
  output logic         store_rd,
  output logic         ram_rd,
  output logic         ram_we,
  output logic         cfg_accept,
  output logic         mm_evt,
  output logic         fin_enter,
  output logic         pon
);
  scrub_state_e state_q, state_d;
  logic         pon_q, pon_en;

  always_comb begin
    state_d    = state_q;
    addr_clr   = 1'b0;
    addr_inc   = 1'b0;
    store_rd   = 1'b0;
    ram_rd     = 1'b0;
    ram_we     = 1'b0;
    cfg_accept = 1'b0;
    mm_evt     = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (cfg_req) begin
          cfg_accept = 1'b1;
          addr_clr   = 1'b1;
          state_d    = S_CK_RD;
        end
      end
      S_LD_RD: begin
        store_rd = 1'b1;
        state_d  = S_LD_WR;
      end
      S_LD_WR: begin
        ram_we = 1'b1;
        if (last) begin
          addr_clr = 1'b1;
          state_d  = S_VF_RD;
        end else begin
          addr_inc = 1'b1;
          state_d  = S_LD_RD;
        end
      end
      S_VF_RD: begin
        store_rd = 1'b1;
        ram_rd   = 1'b1;
        state_d  = S_VF_CMP;
      end
      S_VF_CMP: begin
        if (differ) begin
          mm_evt   = 1'b1;
          addr_clr = 1'b1;
          state_d  = S_FIN;
        end else if (last) begin
          addr_clr = 1'b1;
          state_d  = S_FIN;
        end else begin
          addr_inc = 1'b1;
          state_d  = S_VF_RD;
        end
      end
      S_CK_RD: begin
        store_rd = 1'b1;
        ram_rd   = 1'b1;
        state_d  = S_CK_CMP;
      end
      S_CK_CMP: begin
        if (differ) begin
          mm_evt   = 1'b1;
          addr_clr = 1'b1;
          state_d  = S_RW_RD;
        end else if (last) begin
          addr_clr = 1'b1;
          state_d  = S_FIN;
        end else begin
          addr_inc = 1'b1;
          state_d  = S_CK_RD;
        end
      end
      S_RW_RD: begin
        store_rd = 1'b1;
        state_d  = S_RW_WR;
      end
      S_RW_WR: begin
        ram_we = 1'b1;
        if (last) begin
          addr_clr = 1'b1;
          state_d  = S_FIN;
        end else begin
          addr_inc = 1'b1;
          state_d  = S_RW_RD;
        end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign fin_enter = (state_d == S_FIN) && (state_q != S_FIN);
  assign pon_en    = (state_q == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_LD_RD;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pon_q <= 1'b1;
    else if (pon_en) pon_q <= 1'b0;
  end

  assign state = state_q;
  assign pon   = pon_q;

  // R6: a request while busy never starts a new check
  a_r6_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && state_q != S_CK_CMP) |=> (state_q != S_CK_RD));

  // R1: the operation after the done cycle is never another done cycle
  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FIN) |=> (state_q != S_FIN));
endmodule

// File: rtl/scrub_status.sv
module scrub_status #(
  parameter int CNT_W     = 4,
  parameter int SUSPECT_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_accept,
  input  logic             mm_evt,
  input  logic             fin_enter,
  input  logic             pon,
  output logic             warn,
  output logic             err,
  output logic             suspect,
  output logic [CNT_W-1:0] count
);
  localparam int                RUN_W   = $clog2(SUSPECT_N + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;
  localparam logic [RUN_W-1:0]  RUN_TOP = RUN_W'(SUSPECT_N);

  logic             hit_q, hit_d, hit_eff;
  logic             warn_q, warn_d;
  logic             err_q, err_d;
  logic             sus_q, sus_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RUN_W-1:0] run_q, run_d, run_inc;
  logic             cfg_done;

  assign hit_eff  = hit_q | mm_evt;
  assign cfg_done = fin_enter & ~pon;
  assign run_inc  = (run_q == RUN_TOP) ? run_q : run_q + 1'b1;

  always_comb begin
    hit_d  = hit_q;
    warn_d = warn_q;
    err_d  = err_q;
    sus_d  = sus_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    if (cfg_accept) begin
      hit_d  = 1'b0;
      warn_d = 1'b0;
    end else if (mm_evt) begin
      hit_d = 1'b1;
    end
    if (fin_enter && pon) begin
      err_d = err_q | hit_eff;
    end
    if (cfg_done) begin
      warn_d = hit_eff;
      if (hit_eff) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        run_d = run_inc;
        if (run_inc >= RUN_TOP) sus_d = 1'b1;
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      warn_q <= 1'b0;
      err_q  <= 1'b0;
      sus_q  <= 1'b0;
      cnt_q  <= '0;
      run_q  <= '0;
    end else begin
      hit_q  <= hit_d;
      warn_q <= warn_d;
      err_q  <= err_d;
      sus_q  <= sus_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
    end
  end

  assign warn    = warn_q;
  assign err     = err_q;
  assign suspect = sus_q;
  assign count   = cnt_q;

  // R2: the power-on error flag is sticky
  a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R8: the store-suspect flag is sticky
  a_r8_suspect_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sus_q |=> sus_q);

  // R7: the repair counter never wraps from its maximum
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R9: an accepted configure clears the warning
  a_r9_warn_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_accept |=> !warn_q);
endmodule

// File: rtl/seqram_scrubber.sv
module seqram_scrubber
  import scrub_pkg::*;
#(
  parameter  int DEPTH     = 16,
  parameter  int WIDTH     = 16,
  parameter  int CNT_W     = 4,
  parameter  int SUSPECT_N = 3,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_req,
  output logic             busy,
  output logic             done,
  output logic             warn,
  output logic             err,
  output logic             store_suspect,
  output logic [CNT_W-1:0] repair_count,
  output logic             store_rd,
  output logic [AW-1:0]    store_addr,
  input  logic [WIDTH-1:0] store_data,
  output logic             ram_rd,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr,
  output logic [WIDTH-1:0] ram_wdata,
  input  logic [WIDTH-1:0] ram_rdata
);
  scrub_state_e  state;
  logic          addr_clr, addr_inc, last;
  logic [AW-1:0] addr;
  logic          differ, cfg_accept, mm_evt, fin_enter, pon;

  assign differ = (store_data != ram_rdata);

  scrub_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (addr_clr),
    .inc   (addr_inc),
    .addr  (addr),
    .last  (last)
  );

  scrub_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_req    (cfg_req),
    .last       (last),
    .differ     (differ),
    .state      (state),
    .addr_clr   (addr_clr),
    .addr_inc   (addr_inc),
    .store_rd   (store_rd),
    .ram_rd     (ram_rd),
    .ram_we     (ram_we),
    .cfg_accept (cfg_accept),
    .mm_evt     (mm_evt),
    .fin_enter  (fin_enter),
    .pon        (pon)
  );

  scrub_status #(.CNT_W(CNT_W), .SUSPECT_N(SUSPECT_N)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_accept (cfg_accept),
    .mm_evt     (mm_evt),
    .fin_enter  (fin_enter),
    .pon        (pon),
    .warn       (warn),
    .err        (err),
    .suspect    (store_suspect),
    .count      (repair_count)
  );

  assign store_addr = addr;
  assign ram_addr   = addr;
  assign ram_wdata  = store_data;
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_FIN);

  // R5: every RAM write carries data fetched from the store one cycle earlier
  a_r5_write_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(store_rd));

  // R1: done is only ever raised inside a busy window
  a_r1_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

// File: tb/seqram_scrubber_tb.sv
module seqram_scrubber_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int WIDTH      = 16;
  localparam int CNT_W      = 4;
  localparam int SUSPECT_N  = 3;
  localparam int AW         = $clog2(DEPTH);
  localparam int CNT_MAX    = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_req = 1'b0;
  logic             busy, done, warn, err, store_suspect;
  logic [CNT_W-1:0] repair_count;
  logic             store_rd, ram_rd, ram_we;
  logic [AW-1:0]    store_addr, ram_addr;
  logic [WIDTH-1:0] store_data, ram_wdata, ram_rdata;

  logic [WIDTH-1:0] st_mem [DEPTH];
  logic [WIDTH-1:0] ram_mem [DEPTH];

  // environment controls
  logic             inj_en = 1'b0;
  int               inj_addr = 0;
  logic [WIDTH-1:0] inj_xor = '0;
  logic             fault_en = 1'b0;
  int               fault_addr = 3;
  logic             fault_val = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seqram_scrubber #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W), .SUSPECT_N(SUSPECT_N)) u_dut (
    .clk (clk), .rst_n (rst_n), .cfg_req (cfg_req),
    .busy (busy), .done (done), .warn (warn), .err (err),
    .store_suspect (store_suspect), .repair_count (repair_count),
    .store_rd (store_rd), .store_addr (store_addr), .store_data (store_data),
    .ram_rd (ram_rd), .ram_we (ram_we), .ram_addr (ram_addr),
    .ram_wdata (ram_wdata), .ram_rdata (ram_rdata)
  );

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      st_mem[i]  = WIDTH'((i * 16'h1357) ^ 16'hA5A4);
      ram_mem[i] = '0;
    end
  end

  // backing store: synchronous read
  always @(posedge clk) if (store_rd) store_data <= st_mem[store_addr];

  // sequencer RAM: synchronous read, write with optional stuck bit 0, injection port
  always @(posedge clk) begin
    if (ram_rd) ram_rdata <= ram_mem[ram_addr];
    if (ram_we) begin
      if (fault_en && int'(ram_addr) == fault_addr)
        ram_mem[ram_addr] <= {ram_wdata[WIDTH-1:1], fault_val};
      else
        ram_mem[ram_addr] <= ram_wdata;
    end else if (inj_en) begin
      ram_mem[inj_addr] <= ram_mem[inj_addr] ^ inj_xor;
    end
  end

  // ---------------- reference model ----------------
  int rem, consec, cnt_m;
  bit pon_m, hit_m, warn_m, err_m, sus_m;

  function automatic int first_diff();
    for (int i = 0; i < DEPTH; i++)
      if (ram_mem[i] != st_mem[i]) return i;
    return DEPTH;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem    = 2*DEPTH + (fault_en ? 2*(fault_addr + 1) : 2*DEPTH) + 1;
      pon_m  = 1; hit_m = fault_en;
      warn_m = 0; err_m = 0; sus_m = 0; cnt_m = 0; consec = 0;
    end else if (rem == 0) begin
      if (cfg_req) begin
        int k;
        k      = first_diff();
        hit_m  = (k < DEPTH);
        rem    = (hit_m ? 2*(k + 1) + 2*DEPTH : 2*DEPTH) + 1;
        pon_m  = 0;
        warn_m = 0;
      end
    end else begin
      rem = rem - 1;
      if (rem == 1) begin
        if (pon_m) err_m = err_m | hit_m;
        else begin
          warn_m = hit_m;
          if (hit_m) begin
            if (cnt_m < CNT_MAX) cnt_m = cnt_m + 1;
            consec = consec + 1;
            if (consec >= SUSPECT_N) sus_m = 1;
          end else consec = 0;
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit b_exp, d_exp;
      b_exp = (rem > 0);
      d_exp = (rem == 1);
      n_cmp++;
      if (busy !== b_exp || done !== d_exp || warn !== warn_m || err !== err_m ||
          store_suspect !== sus_m || int'(repair_count) != cnt_m) begin
        n_bad++;
        if (busy !== b_exp)
          $display("FAIL R5 busy t=%0t act=%0b exp=%0b", $time, busy, b_exp);
        if (done !== d_exp)
          $display("FAIL R4 done t=%0t act=%0b exp=%0b", $time, done, d_exp);
        if (warn !== warn_m)
          $display("FAIL R9 warn t=%0t act=%0b exp=%0b", $time, warn, warn_m);
        if (err !== err_m)
          $display("FAIL R2 err t=%0t act=%0b exp=%0b", $time, err, err_m);
        if (store_suspect !== sus_m)
          $display("FAIL R8 suspect t=%0t act=%0b exp=%0b", $time, store_suspect, sus_m);
        if (int'(repair_count) != cnt_m)
          $display("FAIL R7 count t=%0t act=%0d exp=%0d", $time, repair_count, cnt_m);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_cfg();
    @(negedge clk);
    cfg_req = 1'b1;
    @(negedge clk);
    cfg_req = 1'b0;
  endtask

  task automatic corrupt(input int a, input logic [WIDTH-1:0] x);
    @(negedge clk);
    inj_en = 1'b1; inj_addr = a; inj_xor = x;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic check_ram(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (ram_mem[i] != st_mem[i]) bad++;
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic run_cfg();
    pulse_cfg();
    wait_idle();
  endtask

  initial begin
    do_reset();
    wait_idle();
    check_ram("R1 ram equals store after power-on load");
    check(err == 1'b0, "R2 clean verify leaves err low", int'(err), 0);

    run_cfg();
    check(warn == 1'b0, "R4 clean check warn low", int'(warn), 0);
    check_ram("R4 clean check leaves ram intact");

    corrupt(9, 16'h0100);
    run_cfg();
    check(warn == 1'b1, "R5 repair raises warn", int'(warn), 1);
    check_ram("R5 ram restored after mid-image repair");

    corrupt(0, 16'h8001);
    run_cfg();
    check_ram("R5 ram restored after word 0 repair");
    check(int'(repair_count) == 2, "R7 count after two repairs", int'(repair_count), 2);

    run_cfg();
    check(store_suspect == 1'b0, "R8 clean configure resets run", int'(store_suspect), 0);

    corrupt(DEPTH-1, 16'h0040);
    run_cfg();
    check_ram("R5 ram restored after last word repair");

    // R6: second request during a busy window is dropped
    pulse_cfg();
    repeat (5) @(negedge clk);
    cfg_req = 1'b1;
    @(negedge clk);
    cfg_req = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R6 request while busy not queued", int'(busy), 0);
    check(warn == 1'b0, "R3 accepted check on clean ram", int'(warn), 0);

    corrupt(4, 16'h0002);
    run_cfg();
    corrupt(7, 16'h0020);
    run_cfg();
    check(store_suspect == 1'b0, "R8 two in a row not suspect", int'(store_suspect), 0);
    run_cfg();
    check(warn == 1'b0, "R9 warn refreshed by clean check", int'(warn), 0);

    // stuck RAM bit: every check repairs
    fault_val = ~st_mem[fault_addr][0];
    fault_en  = 1'b1;
    corrupt(fault_addr, 16'h0001);
    run_cfg();
    run_cfg();
    check(store_suspect == 1'b0, "R8 suspect waits for third", int'(store_suspect), 0);
    run_cfg();
    check(store_suspect == 1'b1, "R8 suspect after three repairs", int'(store_suspect), 1);
    for (int i = 0; i < 10; i++) run_cfg();
    check(int'(repair_count) == CNT_MAX, "R7 count saturates", int'(repair_count), CNT_MAX);

    // power-on with stuck bit: verify must flag err
    do_reset();
    wait_idle();
    check(err == 1'b1, "R2 verify mismatch sets err", int'(err), 1);
    run_cfg();
    check(err == 1'b1, "R2 err stays set", int'(err), 1);
    check(warn == 1'b1, "R3 configure after reset checks ram", int'(warn), 1);

    repeat (2) @(negedge clk);
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired act=%0d exp=%0d", 1, 0);
    report();
    $finish;
  end
endmodule